// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Operations

This block is one 16-pin slice of a general-purpose I/O port, reached over a small register bus. Each pin has a direction bit and a function-select bit. The function-select bit routes the pad either to the port's own output latch and direction register, or to a primary peripheral that supplies its own output value and output enable. The pad is not instantiated here. The slice exposes a separate output value and output enable for each pin, which the pad ring turns into a tristate driver.

Software can load the output latch as a whole word. It can also change individual bits without a read-modify-write, through three write-only strobe registers that set, clear or invert the bits written as 1. A read of the data register does not return the latch. It returns the pin levels after a two-flop synchroniser and an input qualifier. The qualifier passes a new level only when six consecutive samples agree. Samples are taken every 2·N clocks, where N is a programmable period. A period of zero gives synchronisation only. The same qualified levels also drive the peripheral-side inputs.

Top module: `pio_port`

## Requirements
- R1: While reset is held, the latch, direction, function-select and period registers clear to zero. On the clock after any reset cycle, `pad_oe` and `pad_out` are all zero.
- R2: When a pin's function bit (address 5) is 0, `pad_oe` follows that pin's direction bit (address 4; 1 = output, 0 = input) and `pad_out` follows its latch bit. Both outputs are registered, so they change one clock after the register changes.
- R3: When a pin's function bit is 1, that pin's `pad_out` and `pad_oe` follow `periph_out` and `periph_oe`, one clock later, and the latch and direction bits have no effect on that pin.
- R4: A write to address 0 loads the whole output latch. A read of address 0 returns the qualified pin levels and not the latch. `periph_in` carries the same qualified levels.
- R5: A write to address 1 sets every latch bit written as 1 and leaves bits written as 0 unchanged.
- R6: A write to address 2 clears every latch bit written as 1 and leaves bits written as 0 unchanged.
- R7: A write to address 3 inverts every latch bit written as 1 and leaves bits written as 0 unchanged.
- R8: Reads of addresses 1, 2 and 3, and of the unused address 7, return zero. Read data appears on `bus_rdata` the clock after `bus_re`.
- R9: Address 6 holds the qualification period in bits 7:0. Bits 15:8 are reserved: they ignore writes and read as zero.
- R10: With period 0, a pin level change reaches the qualified value three clocks after it reaches `pin_in`: two synchroniser stages plus one register.
- R11: With period N > 0, samples are taken every 2·N clocks. The qualified value changes only after six consecutive samples agree on the new level, and only on a sample clock. A pulse shorter than six sample periods is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the clock after `bus_re` |
| pin_in | input | 16 | Raw pad input levels |
| periph_out | input | 16 | Peripheral output values |
| periph_oe | input | 16 | Peripheral output enables |
| periph_in | output | 16 | Qualified pin levels to the peripheral |
| pad_out | output | 16 | Registered pad output value |
| pad_oe | output | 16 | Registered pad output enable |

## Verification
A corrupted latch bit shows on `pad_out` one clock after the faulty write for an output pin routed to the port. It does not show on a data read, because reads return the pins. The bench therefore checks strobe operations at the pad outputs.

A wrong qualifier count or sample divider shows only as a timing error: a level that passes too early, or a glitch that gets through. The bench brackets the first qualified change with reads taken both before and after the earliest legal cycle, at two different periods.

A stuck function-select bit swaps the source of `pad_out` and `pad_oe` on the next clock. The bench exposes this by driving the peripheral values opposite to the latch.

// File: rtl/pio_pkg.sv
package pio_pkg;
  parameter int unsigned PIO_AW = 3;

  typedef enum logic [PIO_AW-1:0] {
    REG_DATA   = 3'd0,
    REG_SET    = 3'd1,
    REG_CLR    = 3'd2,
    REG_TGL    = 3'd3,
    REG_DIR    = 3'd4,
    REG_FUNC   = 3'd5,
    REG_QUAL   = 3'd6,
    REG_UNUSED = 3'd7
  } pio_reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pio_tick.sv
module pio_tick #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period,
  output logic          tick
);
  localparam int unsigned CW = PW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = (CW'(period) << 1) - CW'(1);
  assign tick  = (period != '0) && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || period == '0 || tick) cnt_q <= '0;
    else                             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pio_qual.sv
module pio_qual #(
  parameter int unsigned NSAMP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic tick,
  input  logic s,
  output logic q
);
  localparam int unsigned CW = (NSAMP > 2) ? $clog2(NSAMP) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= 1'b0;
      cnt_q <= '0;
    end else if (bypass) begin
      q     <= s;
      cnt_q <= '0;
    end else if (tick) begin
      if (s == q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(NSAMP - 1)) begin
        q     <= s;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned PW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [PIO_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pins_qual,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      func_q,
  output logic [PW-1:0]     period_q,
  output logic [W-1:0]      rdata
);
  pio_reg_e sel;
  assign sel = pio_reg_e'(addr);

  logic [W-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (we) begin
      unique case (sel)
        REG_DATA: latch_d = wdata;
        REG_SET:  latch_d = latch_q | wdata;
        REG_CLR:  latch_d = latch_q & ~wdata;
        REG_TGL:  latch_d = latch_q ^ wdata;
        default:  latch_d = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= '0;
      dir_q    <= '0;
      func_q   <= '0;
      period_q <= '0;
    end else begin
      latch_q <= latch_d;
      if (we && sel == REG_DIR)  dir_q    <= wdata;
      if (we && sel == REG_FUNC) func_q   <= wdata;
      if (we && sel == REG_QUAL) period_q <= wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      unique case (sel)
        REG_DATA: rdata <= pins_qual;
        REG_DIR:  rdata <= dir_q;
        REG_FUNC: rdata <= func_q;
        REG_QUAL: rdata <= W'(period_q);
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned PW        = 8,
  parameter int unsigned SYNC_STGS = 2,
  parameter int unsigned NSAMP     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [PIO_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      periph_out,
  input  logic [W-1:0]      periph_oe,
  output logic [W-1:0]      periph_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);
  logic [W-1:0]  latch_q, dir_q, func_q;
  logic [PW-1:0] period_q;
  logic [W-1:0]  pins_sync, pins_qual;
  logic          tick;

  pio_regs #(.W(W), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .pins_qual(pins_qual), .latch_q(latch_q),
    .dir_q(dir_q), .func_q(func_q), .period_q(period_q), .rdata(bus_rdata)
  );

  pio_sync #(.W(W), .STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  pio_tick #(.PW(PW)) u_tick (
    .clk(clk), .rst(rst), .period(period_q), .tick(tick)
  );

  for (genvar g = 0; g < W; g++) begin : g_qual
    pio_qual #(.NSAMP(NSAMP)) u_qual (
      .clk(clk), .rst(rst), .bypass(period_q == '0), .tick(tick),
      .s(pins_sync[g]), .q(pins_qual[g])
    );
  end

  assign periph_in = pins_qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= (func_q & periph_out) | (~func_q & latch_q);
      pad_oe  <= (func_q & periph_oe)  | (~func_q & dir_q);
    end
  end
endmodule

module pio_port_chk
  import pio_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned PW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [PIO_AW-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      latch_q,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      func_q,
  input logic [PW-1:0]     period_q,
  input logic              tick,
  input logic [W-1:0]      pins_qual
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0));

  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
    (func_q == '0) |=> (pad_oe == $past(dir_q)));

  a_r5_set_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_SET) |=>
      ((latch_q & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((latch_q & ~$past(bus_wdata)) == ($past(latch_q) & ~$past(bus_wdata))));

  a_r6_clr_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_CLR) |=>
      ((latch_q & $past(bus_wdata)) == '0) &&
      ((latch_q & ~$past(bus_wdata)) == ($past(latch_q) & ~$past(bus_wdata))));

  a_r7_tgl_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_TGL) |=>
      (latch_q == ($past(latch_q) ^ $past(bus_wdata))));

  a_r8_strobe_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr == REG_SET || bus_addr == REG_CLR ||
                bus_addr == REG_TGL || bus_addr == REG_UNUSED)) |=> (bus_rdata == '0));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == REG_QUAL) |=> (bus_rdata[W-1:PW] == '0));

  a_r11_change_on_tick: assert property (@(posedge clk) disable iff (rst)
    (period_q != '0 && !tick) |=> $stable(pins_qual));
endmodule

bind pio_port pio_port_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .latch_q(latch_q), .dir_q(dir_q), .func_q(func_q),
  .period_q(period_q), .tick(tick), .pins_qual(pins_qual)
);

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we, bus_re;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [15:0] pin_in, periph_out, periph_oe, periph_in, pad_out, pad_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pio_port i_pio_port (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 pad_oe", pad_oe, 16'h0000);
    check("R1 pad_out", pad_out, 16'h0000);
    rd(3'd4, v); check("R1 dir", v, 16'h0000);
    rd(3'd5, v); check("R1 func", v, 16'h0000);
    rd(3'd6, v); check("R1 period", v, 16'h0000);
  endtask

  task automatic t_dir_latch;
    wr(3'd4, 16'hFFFF);
    wr(3'd0, 16'hA5C3);
    wait_clk(1);
    check("R2 pad_oe", pad_oe, 16'hFFFF);
    check("R4 latch load", pad_out, 16'hA5C3);
    wr(3'd4, 16'h00F0);
    wait_clk(1);
    check("R2 pad_oe partial", pad_oe, 16'h00F0);
  endtask

  task automatic t_strobes;
    wr(3'd4, 16'hFFFF);
    wr(3'd0, 16'h1234);
    wr(3'd1, 16'h8001);
    wait_clk(1);
    check("R5 set", pad_out, 16'h9235);
    wr(3'd2, 16'h0231);
    wait_clk(1);
    check("R6 clear", pad_out, 16'h9004);
    wr(3'd3, 16'hFF00);
    wait_clk(1);
    check("R7 toggle", pad_out, 16'h6F04);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);
    wait_clk(1);
    check("R7 zero-mask strobes", pad_out, 16'h6F04);
  endtask

  task automatic t_func;
    periph_out = 16'h0F0F; periph_oe = 16'h3333;
    wr(3'd0, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    wr(3'd5, 16'hFF00);
    wait_clk(1);
    check("R3 pad_out mux", pad_out, 16'h0FFF);
    check("R3 pad_oe mux", pad_oe, 16'h33FF);
    periph_out = 16'hF000;
    wait_clk(2);
    check("R3 follows peripheral", pad_out, 16'hF0FF);
    wr(3'd5, 16'h0000);
    wait_clk(1);
    check("R3 back to port", pad_out, 16'hFFFF);
  endtask

  task automatic t_reads;
    logic [15:0] v;
    rd(3'd1, v); check("R8 set reads 0", v, 16'h0000);
    rd(3'd2, v); check("R8 clear reads 0", v, 16'h0000);
    rd(3'd3, v); check("R8 toggle reads 0", v, 16'h0000);
    rd(3'd7, v); check("R8 unused reads 0", v, 16'h0000);
    wr(3'd6, 16'hAB5A);
    rd(3'd6, v); check("R9 reserved bits", v, 16'h005A);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_sync_only;
    logic [15:0] v;
    pin_in = 16'h0000;
    wr(3'd0, 16'hFFFF);
    wait_clk(4);
    rd(3'd0, v); check("R4 read returns pins not latch", v, 16'h0000);
    @(negedge clk); pin_in = 16'hC3A5;
    wait_clk(2);
    check("R10 not yet at 2 clocks", periph_in, 16'h0000);
    wait_clk(1);
    check("R10 visible at 3 clocks", periph_in, 16'hC3A5);
    rd(3'd0, v); check("R4 data read", v, 16'hC3A5);
  endtask

  task automatic t_qual(logic [15:0] per, int early, int late);
    logic [15:0] v;
    pin_in = 16'h0000;
    wr(3'd6, 16'h0000);
    wait_clk(4);
    wr(3'd6, per);
    @(negedge clk); pin_in = 16'h00FF;
    wait_clk(early);
    rd(3'd0, v); check("R11 held before six samples", v, 16'h0000);
    wait_clk(late);
    rd(3'd0, v); check("R11 passed after six samples", v, 16'h00FF);
    @(negedge clk); pin_in = 16'h0000;
    wait_clk(int'(per) * 4);
    pin_in = 16'h00FF;
    wait_clk(int'(per) * 20);
    rd(3'd0, v); check("R11 short glitch rejected", v, 16'h00FF);
  endtask

  initial begin
    rst = 1'b1; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    pin_in = 0; periph_out = 0; periph_oe = 0;
    wait_clk(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_dir_latch();
    t_strobes();
    t_func();
    t_reads();
    t_sync_only();
    t_qual(16'h0001, 6, 20);
    t_qual(16'h0003, 20, 50);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule